// File: doc/BRIEF.md
# Current-Sense ADC Control Register Block

This block is the host-visible register side of a current-measuring ADC. A host on a simple byte-wide read/write bus reads fixed identification bytes, programs the operating mode, the input selection, decimation, settle delay and averaging, switches the converter on, and asks for a conversion. The host then watches a status byte and reads back a 16-bit result as two bytes.

One reset-control byte is protected. It accepts a write only when the access comes straight after a key byte written to a separate key address. The key is good for a single access. Any other access, including a read, uses up the key.

Conversions are carried out by a stub converter inside the block. It waits a fixed number of cycles and then latches the value on an input port as the result. This lets the register interface and the status sequencing be exercised without any analog circuitry.

Top module: `isadc_regs`

## Requirements
- R1: Offsets 0x01, 0x04 and 0x05 read the identification values given by parameters (defaults 1, 8 and 3). Writes to these offsets change nothing.
- R2: Writing 0xA5 to offset 0xD0 arms the key. A write to offset 0xDA while the key is armed stores all 8 bits, and 0xDA reads back the stored byte. Bit 2 of that byte is the follow-warm-reset select.
- R3: A write to 0xDA without an armed key is ignored. Writing any value other than 0xA5 to 0xD0 leaves the key disarmed.
- R4: The key serves exactly one access. Any read, and any write to an offset other than 0xD0, disarms it. A second protected write, or a protected write that follows a read, is therefore ignored.
- R5: Offsets 0x40 (mode, trim flag in bit 0, mode from bit 3 upward), 0x48 (input select), 0x50 (decimation from bit 2 upward), 0x51 (settle) and 0x5A (average count) store and read back all 8 bits. Offsets 0x46 (enable) and 0x5B (averaging on) keep only bit 7, and their other bits read 0.
- R6: Writing bit 7 of offset 0x52 while enabled starts a conversion. From the next cycle, status offset 0x08 reads bits[1:0] = 0b10 (bit 1 is request pending, bit 0 is end of conversion), and bit 7 of 0x52 reads 1. Exactly CONV_CYCLES cycles after the request edge, the status reads 0b01.
- R7: When a conversion ends, the input conv_value is latched as the result. The result reads low byte at 0x60 and high byte at 0x61, and it does not change until the next conversion completes.
- R8: A request written while the enable bit is 0 is ignored. The status stays 0b00 and the result is unchanged.
- R9: Writing 0x46 with bit 7 clear during a conversion aborts it. Both status bits clear in the next cycle, stay clear, and the result is not updated.
- R10: After reset, every control byte, the protected byte, the status and the result read 0, and the key is disarmed.
- R11: A read of any offset not listed returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high, 0 otherwise |
| conv_value | input | 16 | Value the stub converter latches when a conversion ends |

## Verification
The bench targets the single-use key in three ways: a wrong key value, a second protected write after one key, and a read placed between the key and the protected write. A design that keeps the key armed, or that ignores reads when deciding whether to disarm, would let the protected byte change in these cases. Conversion timing is sampled one cycle before and exactly at the end count, so a counter that is off by one reports end of conversion early or late. Abort and requests made while disabled are checked well past the end count, which exposes a design that finishes the conversion anyway or overwrites the result. Changing conv_value after a conversion catches a result register that follows its input instead of latching it.

// File: rtl/isadc_pkg.sv
package isadc_pkg;
  localparam int BYTE_W = 8;
  localparam int RES_W  = 16;

  localparam logic [7:0] A_REV     = 8'h01;
  localparam logic [7:0] A_TYPE    = 8'h04;
  localparam logic [7:0] A_SUBTYPE = 8'h05;
  localparam logic [7:0] A_STATUS  = 8'h08;
  localparam logic [7:0] A_MODE    = 8'h40;
  localparam logic [7:0] A_ENABLE  = 8'h46;
  localparam logic [7:0] A_INSEL   = 8'h48;
  localparam logic [7:0] A_DECIM   = 8'h50;
  localparam logic [7:0] A_SETTLE  = 8'h51;
  localparam logic [7:0] A_REQ     = 8'h52;
  localparam logic [7:0] A_AVGCNT  = 8'h5A;
  localparam logic [7:0] A_AVGON   = 8'h5B;
  localparam logic [7:0] A_RES_LO  = 8'h60;
  localparam logic [7:0] A_RES_HI  = 8'h61;
  localparam logic [7:0] A_KEY     = 8'hD0;
  localparam logic [7:0] A_PROT    = 8'hDA;

  localparam logic [7:0] KEY_CODE  = 8'hA5;
  localparam int         CTL_BIT   = 7;
endpackage

// File: rtl/isadc_unlock.sv
module isadc_unlock
  import isadc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic              key_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic              armed
);
  logic armed_q, armed_d, armed_en;

  // The key register only updates when some bus access occurs.
  assign armed_en = wr | rd;

  always_comb begin
    armed_d = armed_q;
    if (wr && key_sel) armed_d = (wdata == KEY_CODE);
    else if (armed_en) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign armed = armed_q;

  // Every access except a key write uses up the armed key.
  p_key_single_use_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && (rd || (wr && !key_sel))) |=> !armed_q);

  // A key write with the wrong value leaves the key disarmed.
  p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && key_sel && wdata != KEY_CODE) |=> !armed_q);
endmodule

// File: rtl/isadc_conv.sv
module isadc_conv
  import isadc_pkg::*;
#(
  parameter int CONV_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [RES_W-1:0] sample,
  output logic             pending,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic             pend_q, pend_d;
  logic             eoc_q,  eoc_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic [RES_W-1:0] res_q,  res_d;
  logic             finish, res_en;

  assign finish = pend_q && (cnt_q == '0) && !abort;
  assign res_en = finish;

  always_comb begin
    pend_d = pend_q;
    eoc_d  = eoc_q;
    cnt_d  = cnt_q;
    res_d  = sample;
    if (abort) begin
      pend_d = 1'b0;
      eoc_d  = 1'b0;
    end else if (start) begin
      pend_d = 1'b1;
      eoc_d  = 1'b0;
      cnt_d  = CNT_LOAD;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        pend_d = 1'b0;
        eoc_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      eoc_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      eoc_q  <= eoc_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign pending = pend_q;
  assign done    = eoc_q;
  assign result  = res_q;

  p_start_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (pend_q && !eoc_q));

  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && eoc_q));

  p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!pend_q && !eoc_q));

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && cnt_q == '0) |=> $stable(res_q));
endmodule

// File: rtl/isadc_regs.sv
module isadc_regs
  import isadc_pkg::*;
#(
  parameter logic [7:0] REV_ID      = 8'd1,
  parameter logic [7:0] TYPE_ID     = 8'd8,
  parameter logic [7:0] SUBTYPE_ID  = 8'd3,
  parameter int         CONV_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [RES_W-1:0]  conv_value
);
  logic [BYTE_W-1:0] mode_q, mode_d;
  logic [BYTE_W-1:0] insel_q, insel_d;
  logic [BYTE_W-1:0] decim_q, decim_d;
  logic [BYTE_W-1:0] settle_q, settle_d;
  logic [BYTE_W-1:0] avgcnt_q, avgcnt_d;
  logic [BYTE_W-1:0] prot_q, prot_d;
  logic              en_q, en_d;
  logic              avgon_q, avgon_d;

  logic              key_armed;
  logic              conv_pend, conv_eoc;
  logic [RES_W-1:0]  conv_res;
  logic              req_start, req_abort;
  logic              reg_en;

  isadc_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .key_sel (bus_addr == A_KEY),
    .wdata   (bus_wdata),
    .armed   (key_armed)
  );

  assign req_start = bus_wr && (bus_addr == A_REQ) && bus_wdata[CTL_BIT]
                     && en_q && !conv_pend;
  assign req_abort = bus_wr && (bus_addr == A_ENABLE) && !bus_wdata[CTL_BIT];

  isadc_conv #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (req_start),
    .abort   (req_abort),
    .sample  (conv_value),
    .pending (conv_pend),
    .done    (conv_eoc),
    .result  (conv_res)
  );

  assign reg_en = bus_wr;

  always_comb begin
    mode_d   = mode_q;
    insel_d  = insel_q;
    decim_d  = decim_q;
    settle_d = settle_q;
    avgcnt_d = avgcnt_q;
    prot_d   = prot_q;
    en_d     = en_q;
    avgon_d  = avgon_q;
    unique case (bus_addr)
      A_MODE:   mode_d   = bus_wdata;
      A_INSEL:  insel_d  = bus_wdata;
      A_DECIM:  decim_d  = bus_wdata;
      A_SETTLE: settle_d = bus_wdata;
      A_AVGCNT: avgcnt_d = bus_wdata;
      A_ENABLE: en_d     = bus_wdata[CTL_BIT];
      A_AVGON:  avgon_d  = bus_wdata[CTL_BIT];
      A_PROT:   if (key_armed) prot_d = bus_wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      insel_q  <= '0;
      decim_q  <= '0;
      settle_q <= '0;
      avgcnt_q <= '0;
      prot_q   <= '0;
      en_q     <= 1'b0;
      avgon_q  <= 1'b0;
    end else if (reg_en) begin
      mode_q   <= mode_d;
      insel_q  <= insel_d;
      decim_q  <= decim_d;
      settle_q <= settle_d;
      avgcnt_q <= avgcnt_d;
      prot_q   <= prot_d;
      en_q     <= en_d;
      avgon_q  <= avgon_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_REV:     bus_rdata = REV_ID;
        A_TYPE:    bus_rdata = TYPE_ID;
        A_SUBTYPE: bus_rdata = SUBTYPE_ID;
        A_STATUS:  bus_rdata = {6'b0, conv_pend, conv_eoc};
        A_MODE:    bus_rdata = mode_q;
        A_ENABLE:  bus_rdata = {en_q, 7'b0};
        A_INSEL:   bus_rdata = insel_q;
        A_DECIM:   bus_rdata = decim_q;
        A_SETTLE:  bus_rdata = settle_q;
        A_REQ:     bus_rdata = {conv_pend, 7'b0};
        A_AVGCNT:  bus_rdata = avgcnt_q;
        A_AVGON:   bus_rdata = {avgon_q, 7'b0};
        A_RES_LO:  bus_rdata = conv_res[7:0];
        A_RES_HI:  bus_rdata = conv_res[15:8];
        A_PROT:    bus_rdata = prot_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // A protected write without the key leaves the byte untouched.
  p_prot_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PROT && !key_armed) |=> $stable(prot_q));

  // A request while disabled must not raise the pending flag.
  p_req_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_REQ && !en_q && !conv_pend) |=> !conv_pend);
endmodule

// File: tb/sim_isadc_regs.sv
module sim_isadc_regs;
  localparam int CYC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] conv_value = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  isadc_regs #(.CONV_CYCLES(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_value(conv_value)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // Tasks start and end just after a falling edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_rd = 1'b1; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R10 mode", 8'h40, 8'h00);
    rd_chk("R10 prot", 8'hDA, 8'h00);
    rd_chk("R10 status", 8'h08, 8'h00);
    rd_chk("R10 res lo", 8'h60, 8'h00);
    rd_chk("R10 res hi", 8'h61, 8'h00);
    rd_chk("R11 unmapped", 8'h33, 8'h00);
    wr(8'h33, 8'hFF);
    rd_chk("R11 unmapped after write", 8'h33, 8'h00);
  endtask

  task automatic t_ids;
    rd_chk("R1 rev", 8'h01, 8'd1);
    rd_chk("R1 type", 8'h04, 8'd8);
    rd_chk("R1 subtype", 8'h05, 8'd3);
    wr(8'h04, 8'h77);
    rd_chk("R1 type after write", 8'h04, 8'd8);
  endtask

  task automatic t_ctrl;
    wr(8'h40, 8'h09); rd_chk("R5 mode", 8'h40, 8'h09);
    wr(8'h48, 8'h05); rd_chk("R5 insel", 8'h48, 8'h05);
    wr(8'h50, 8'hC4); rd_chk("R5 decim", 8'h50, 8'hC4);
    wr(8'h51, 8'h3C); rd_chk("R5 settle", 8'h51, 8'h3C);
    wr(8'h5A, 8'hA1); rd_chk("R5 avgcnt", 8'h5A, 8'hA1);
    wr(8'h5B, 8'hFF); rd_chk("R5 avgon bit7 only", 8'h5B, 8'h80);
    wr(8'h46, 8'h7F); rd_chk("R5 enable bit7 only", 8'h46, 8'h00);
    wr(8'h5B, 8'h00); rd_chk("R5 avgon clear", 8'h5B, 8'h00);
  endtask

  task automatic t_key;
    wr(8'hDA, 8'h04);
    rd_chk("R3 no key", 8'hDA, 8'h00);
    wr(8'hD0, 8'hA5); wr(8'hDA, 8'h04);
    rd_chk("R2 keyed write", 8'hDA, 8'h04);
    wr(8'hD0, 8'hA5); wr(8'hDA, 8'h14); wr(8'hDA, 8'hFF);
    rd_chk("R4 second write ignored", 8'hDA, 8'h14);
    wr(8'hD0, 8'hA5); rd_chk("R4 read spends key", 8'h01, 8'd1);
    wr(8'hDA, 8'h00);
    rd_chk("R4 write after read ignored", 8'hDA, 8'h14);
    wr(8'hD0, 8'h5A); wr(8'hDA, 8'h00);
    rd_chk("R3 wrong key", 8'hDA, 8'h14);
    wr(8'hD0, 8'hA5); wr(8'h40, 8'h00); wr(8'hDA, 8'h00);
    rd_chk("R4 other write spends key", 8'hDA, 8'h14);
  endtask

  task automatic t_conv;
    conv_value = 16'hBEEF;
    wr(8'h46, 8'h80);
    wr(8'h52, 8'h80);                     // request edge k
    rd_chk("R6 pending next cycle", 8'h08, 8'h02);   // j=0
    idle(CYC - 2);
    rd_chk("R6 still pending at CYC-1", 8'h08, 8'h02);
    rd_chk("R6 eoc at CYC", 8'h08, 8'h01);
    rd_chk("R6 req bit clear", 8'h52, 8'h00);
    conv_value = 16'h1234;
    idle(3);
    rd_chk("R7 result lo", 8'h60, 8'hEF);
    rd_chk("R7 result hi", 8'h61, 8'hBE);
    wr(8'h52, 8'h80);
    rd_chk("R6 req bit reads pending", 8'h52, 8'h80);
    idle(CYC + 2);
    rd_chk("R7 new result lo", 8'h60, 8'h34);
    rd_chk("R7 new result hi", 8'h61, 8'h12);
  endtask

  task automatic t_disabled;
    wr(8'h46, 8'h00);
    rd_chk("R9 disable clears eoc", 8'h08, 8'h00);
    conv_value = 16'hAAAA;
    wr(8'h52, 8'h80);
    rd_chk("R8 no pending", 8'h08, 8'h00);
    idle(CYC + 2);
    rd_chk("R8 no eoc", 8'h08, 8'h00);
    rd_chk("R8 result kept", 8'h60, 8'h34);
  endtask

  task automatic t_abort;
    conv_value = 16'h5555;
    wr(8'h46, 8'h80);
    wr(8'h52, 8'h80);
    idle(3);
    wr(8'h46, 8'h00);
    rd_chk("R9 abort flags", 8'h08, 8'h00);
    idle(CYC + 2);
    rd_chk("R9 no late eoc", 8'h08, 8'h00);
    rd_chk("R9 result lo kept", 8'h60, 8'h34);
    rd_chk("R9 result hi kept", 8'h61, 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ids();
    t_ctrl();
    t_key();
    t_conv();
    t_disabled();
    t_abort();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule